// File: doc/BRIEF.md
# Sampled Prioritized Interrupt Register

This block keeps sixteen pending-interrupt flags for a processor core and reports which one should be serviced next. External requests arrive on active-low pins. They are taken in only when the machine-cycle sync strobe goes from high to low. Each pin drives a fixed level: the power-down pin drives level 0, and the other pins drive levels scattered across the range. Some levels have no pin at all and can only be raised by the core's own machine events, through an internal set port.

A flag that has been raised stays raised until software clears it. Software clears flags with a bit-mask operand on the clear port.

A priority encoder looks at the pending flags that are currently allowed and names the lowest-numbered one. A flag is allowed when its mask bit is set and the global enable is high. Level 0 is always allowed, whatever the mask and enable say.

Top module: `irq_pend_core`

## Requirements
- R1: After synchronous reset, `pend` is all zero and `irq_valid` is 0.
- R2: A pin is sampled only in a cycle where `sync_n` is low and was high at the previous clock edge. Pins held low while the strobe is high or stays low set nothing. The strobe is seen as low in the first cycle after reset.
- R3: On a capture edge, the pins set the following `pend` bits on the next clock edge:
  - `pwr_dn_n` sets bit 0.
  - `usr_req_n[0..5]` set bits 2, 8, 10, 11, 13 and 15.
  - `io_req_n[0..1]` set bits 12 and 14.
- R4: A set `pend` bit stays set until it is cleared, even after its pin returns high.
- R5: `int_set` sets `pend` bits on the next clock edge, but only for levels 1, 3, 4, 5, 6, 7 and 9 (mask 0x02FA). Its other bits are ignored.
- R6: With `clr_stb` high, each `pend` bit whose `clr_bits` bit is 1 is cleared on the next clock edge. If a bit is set and cleared in the same cycle, it ends up set.
- R7: Whenever `pend[0]` is 1, `irq_valid` is 1 and `irq_level` is 0, regardless of `lvl_mask` and `glb_en`.
- R8: Any level other than 0 takes part in selection only if its `lvl_mask` bit is 1 and `glb_en` is 1.
- R9: `irq_level` is the lowest-numbered pending level that is allowed. `irq_valid` is 1 exactly when such a level exists. Both follow `pend`, `lvl_mask` and `glb_en` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_n | input | 1 | Machine-cycle sync strobe; a high-to-low change captures the pins |
| pwr_dn_n | input | 1 | Power-down request, active low, level 0 |
| usr_req_n | input | 6 | User requests, active low, levels 2, 8, 10, 11, 13, 15 |
| io_req_n | input | 2 | I/O requests, active low, levels 12, 14 |
| int_set | input | 16 | Internal machine-event set requests, one bit per level |
| lvl_mask | input | 16 | Per-level enable mask, 1 = allowed |
| glb_en | input | 1 | Global enable for levels 1 to 15 |
| clr_stb | input | 1 | Clear strobe |
| clr_bits | input | 16 | Bit mask of pending levels to clear |
| pend | output | 16 | Pending flags |
| irq_valid | output | 1 | An allowed level is pending |
| irq_level | output | 4 | Number of the selected level |

## Verification
The bench builds the block with the package defaults: sixteen levels, six user pins and two I/O pins. With these values every pin-to-level mapping and every internal-only level can be observed on `pend`. The stimulus drives all pins low on a single strobe edge, and it offers all sixteen bits on `int_set`. This shows that the scattered mapping is exact and that the reserved levels reject pin-free requests. Masking down to a single excluded level, together with holding the strobe low or high across several cycles, covers the edge-only capture and the precedence rules.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int NLVL = 16;
    localparam int LVLW = $clog2(NLVL);
    localparam int NUSR = 6;
    localparam int NIO  = 2;

    typedef logic [NLVL-1:0] lvl_vec_t;

    // Levels that only the core's own machine events may raise.
    localparam lvl_vec_t INTERNAL_ONLY = 16'h02FA;
    localparam int       PWR_LVL       = 0;

    typedef struct packed {
        logic            valid;
        logic [LVLW-1:0] lvl;
    } irq_sel_t;

    function automatic int usr_lvl(input int idx);
        case (idx)
            0:       return 2;
            1:       return 8;
            2:       return 10;
            3:       return 11;
            4:       return 13;
            default: return 15;
        endcase
    endfunction

    function automatic int io_lvl(input int idx);
        return (idx == 0) ? 12 : 14;
    endfunction

endpackage

// File: rtl/irq_sample.sv
module irq_sample
    import irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            sync_n,
    input  logic            pwr_dn_n,
    input  logic [NUSR-1:0] usr_req_n,
    input  logic [NIO-1:0]  io_req_n,
    output lvl_vec_t        cap_vec
);

    logic     sync_q;
    logic     fall;
    lvl_vec_t pin_vec;

    // The strobe is held as low across reset, so a strobe that is already low
    // when reset ends does not count as an edge.
    always_ff @(posedge clk) begin
        if (rst) sync_q <= 1'b0;
        else     sync_q <= sync_n;
    end

    assign fall = sync_q & ~sync_n;

    always_comb begin
        pin_vec          = '0;
        pin_vec[PWR_LVL] = ~pwr_dn_n;
        for (int i = 0; i < NUSR; i++) begin
            pin_vec[usr_lvl(i)] = ~usr_req_n[i];
        end
        for (int j = 0; j < NIO; j++) begin
            pin_vec[io_lvl(j)] = ~io_req_n[j];
        end
    end

    assign cap_vec = fall ? pin_vec : '0;

endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
    import irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  lvl_vec_t set_vec,
    input  lvl_vec_t clr_vec,
    output lvl_vec_t pend
);

    // A set request wins over a clear request for the same bit.
    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~clr_vec) | set_vec;
    end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import irq_pkg::*;
(
    input  lvl_vec_t pend,
    input  lvl_vec_t lvl_mask,
    input  logic     glb_en,
    output irq_sel_t sel
);

    lvl_vec_t allow;

    always_comb begin
        allow          = glb_en ? lvl_mask : '0;
        allow[PWR_LVL] = 1'b1;
    end

    // The scan runs from the highest level down, so the lowest-numbered
    // allowed level is the last one written and wins.
    always_comb begin
        sel = '0;
        for (int i = NLVL - 1; i >= 0; i--) begin
            if (pend[i] && allow[i]) begin
                sel.valid = 1'b1;
                sel.lvl   = i[LVLW-1:0];
            end
        end
    end

endmodule

// File: rtl/irq_pend_core.sv
module irq_pend_core
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_n,
    input  logic             pwr_dn_n,
    input  logic [NUSR-1:0]  usr_req_n,
    input  logic [NIO-1:0]   io_req_n,
    input  logic [NLVL-1:0]  int_set,
    input  logic [NLVL-1:0]  lvl_mask,
    input  logic             glb_en,
    input  logic             clr_stb,
    input  logic [NLVL-1:0]  clr_bits,
    output logic [NLVL-1:0]  pend,
    output logic             irq_valid,
    output logic [LVLW-1:0]  irq_level
);

    lvl_vec_t cap_vec;
    lvl_vec_t set_vec;
    lvl_vec_t clr_vec;
    irq_sel_t sel;

    irq_sample u_sample (
        .clk       (clk),
        .rst       (rst),
        .sync_n    (sync_n),
        .pwr_dn_n  (pwr_dn_n),
        .usr_req_n (usr_req_n),
        .io_req_n  (io_req_n),
        .cap_vec   (cap_vec)
    );

    assign set_vec = cap_vec | (int_set & INTERNAL_ONLY);
    assign clr_vec = clr_stb ? clr_bits : '0;

    irq_pend_reg u_pend (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .pend    (pend)
    );

    irq_prio_enc u_enc (
        .pend     (pend),
        .lvl_mask (lvl_mask),
        .glb_en   (glb_en),
        .sel      (sel)
    );

    assign irq_valid = sel.valid;
    assign irq_level = sel.lvl;

endmodule

// File: rtl/irq_pend_chk.sv
module irq_pend_chk
    import irq_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            sync_n,
    input logic [NLVL-1:0] int_set,
    input logic            glb_en,
    input logic            clr_stb,
    input logic [NLVL-1:0] clr_bits,
    input logic [NLVL-1:0] pend,
    input logic            irq_valid,
    input logic [LVLW-1:0] irq_level
);

    // R7
    lvl0_first_chk: assert property (@(posedge clk) disable iff (rst)
        pend[0] |-> (irq_valid && irq_level == '0));

    // R9
    sel_pending_chk: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> pend[irq_level]);

    // R8
    gate_off_chk: assert property (@(posedge clk) disable iff (rst)
        !glb_en |-> (!irq_valid || irq_level == '0));

    // R4
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_stb |=> ((pend & $past(pend)) == $past(pend)));

    // R2
    no_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (!($past(sync_n) && !sync_n) && int_set == '0)
        |=> ((pend & ~$past(pend)) == '0));

    // R6
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_stb && (int_set & INTERNAL_ONLY) == '0 && !($past(sync_n) && !sync_n))
        |=> ((pend & $past(clr_bits)) == '0));

endmodule

bind irq_pend_core irq_pend_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sync_n    (sync_n),
    .int_set   (int_set),
    .glb_en    (glb_en),
    .clr_stb   (clr_stb),
    .clr_bits  (clr_bits),
    .pend      (pend),
    .irq_valid (irq_valid),
    .irq_level (irq_level)
);

// File: tb/sim_irq_pend_core.sv
module sim_irq_pend_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sync_n = 1'b1;
    logic        pwr_dn_n = 1'b1;
    logic [5:0]  usr_req_n = '1;
    logic [1:0]  io_req_n = '1;
    logic [15:0] int_set = '0;
    logic [15:0] lvl_mask = '0;
    logic        glb_en = 1'b0;
    logic        clr_stb = 1'b0;
    logic [15:0] clr_bits = '0;
    logic [15:0] pend;
    logic        irq_valid;
    logic [3:0]  irq_level;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [15:0] p;
        logic        v;
        logic [3:0]  l;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    always #4 clk = ~clk;

    irq_pend_core u0 (
        .clk       (clk),
        .rst       (rst),
        .sync_n    (sync_n),
        .pwr_dn_n  (pwr_dn_n),
        .usr_req_n (usr_req_n),
        .io_req_n  (io_req_n),
        .int_set   (int_set),
        .lvl_mask  (lvl_mask),
        .glb_en    (glb_en),
        .clr_stb   (clr_stb),
        .clr_bits  (clr_bits),
        .pend      (pend),
        .irq_valid (irq_valid),
        .irq_level (irq_level)
    );

    // Driver side: wait for the edge that registers the inputs, queue the
    // expected result, then leave time for the monitor before the next drive.
    task automatic expect_next(input logic [15:0] p, input logic v,
                               input logic [3:0] l, input string tag);
        exp_t e;
        @(posedge clk);
        e.p = p; e.v = v; e.l = l; e.tag = tag;
        sb_q.push_back(e);
        #2;
    endtask

    // Monitor: compare one time unit after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_chk++;
                if (pend !== e.p || irq_valid !== e.v ||
                    (e.v && irq_level !== e.l)) begin
                    n_fail++;
                    $display("FAIL %s: pend=%h valid=%b lvl=%0d expected pend=%h valid=%b lvl=%0d",
                             e.tag, pend, irq_valid, irq_level, e.p, e.v, e.l);
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        expect_next(16'h0000, 1'b0, 4'd0, "R1 reset state");

        // R2: pins low while strobe stays high.
        usr_req_n = 6'b111110; io_req_n = 2'b10;
        expect_next(16'h0000, 1'b0, 4'd0, "R2 no capture while strobe high");

        // R3: strobe falls, levels 2 and 12 captured.
        sync_n = 1'b0;
        expect_next(16'h1004, 1'b0, 4'd0, "R3 user0->2 io0->12");

        // R4: pins released, strobe stays low.
        usr_req_n = '1; io_req_n = '1;
        expect_next(16'h1004, 1'b0, 4'd0, "R4 bits held after release");

        // R2: rising strobe does not capture.
        sync_n = 1'b1; usr_req_n = 6'b011111; pwr_dn_n = 1'b0;
        expect_next(16'h1004, 1'b0, 4'd0, "R2 rising edge ignored");

        // R7: power-down captured, reported although mask=0 and enable=0.
        sync_n = 1'b0;
        expect_next(16'h9005, 1'b1, 4'd0, "R7 level0 unmaskable");

        // R6: clear level 0; R8: mask open but global enable off.
        sync_n = 1'b1; usr_req_n = '1; pwr_dn_n = 1'b1;
        lvl_mask = 16'hFFFF; clr_stb = 1'b1; clr_bits = 16'h0001;
        expect_next(16'h9004, 1'b0, 4'd0, "R8 global enable off");

        clr_stb = 1'b0; clr_bits = '0; glb_en = 1'b1;
        expect_next(16'h9004, 1'b1, 4'd2, "R9 lowest level wins");

        lvl_mask = 16'hFFFB;
        expect_next(16'h9004, 1'b1, 4'd12, "R8 masked level skipped");

        // R5: only internal levels accepted.
        int_set = 16'hFFFF;
        expect_next(16'h92FE, 1'b1, 4'd1, "R5 internal-only set");

        // R6: set and clear of level 3 in one cycle, set wins.
        int_set = 16'h0008; clr_stb = 1'b1; clr_bits = 16'hFFFF;
        expect_next(16'h0008, 1'b1, 4'd3, "R6 set beats clear");

        int_set = '0; clr_bits = 16'h0008;
        expect_next(16'h0000, 1'b0, 4'd0, "R6 selective clear");

        // R3: every user and I/O pin at once.
        clr_stb = 1'b0; clr_bits = '0;
        usr_req_n = '0; io_req_n = '0;
        expect_next(16'h0000, 1'b0, 4'd0, "R2 strobe high again");

        sync_n = 1'b0;
        expect_next(16'hFD04, 1'b1, 4'd8, "R3 full pin map");

        sync_n = 1'b1; usr_req_n = '1; io_req_n = '1; lvl_mask = '0;
        expect_next(16'hFD04, 1'b0, 4'd0, "R8 all masked");

        @(posedge clk);
        #3;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule